// File: doc/BRIEF.md
# RTC Register Access Engine

This block is the register engine behind the serial-bus slave front end of a real-time clock. A bit-level front end, outside this block, turns bus traffic into byte events: start condition, device-address byte, written byte, request for a byte to read, and stop condition. These events arrive on a valid/ready stream. The block answers read requests on a second valid/ready stream. It serves a 20-location byte register space (00h to 13h), which is split into four sections: the time registers (00h to 06h), control/status (07h to 0Bh), alarm (0Ch to 11h) and two bytes of user RAM (12h to 13h).

The time registers are not stored here. The external timekeeping counter supplies them live on `tk_time`. A write to one of them becomes a one-cycle load strobe to that counter, and the strobe is only issued while the time-write enable (bit 4 of register 07h) is set. A read transaction copies all seven time bytes into a holding buffer when its address byte arrives, so a tick during the burst cannot tear the returned time. The alarm registers are local, and a read transaction cannot change them. A pointer carries over between transactions: in a write transaction the first data byte loads it, and each data byte or read byte advances it. It wraps inside the current section.

Back-pressure: an event is taken on a cycle where `ev_valid` and `ev_ready` are both high. The block holds `ev_ready` low while a read byte waits in its output register. A read byte is offered with `rd_valid` and stays stable until the cycle in which `rd_ready` is high.

Top module: `rtc_regfile_ctrl`

## Requirements
- R1: After reset the pointer is 00h, every stored register (07h to 13h) reads 00h, `rd_valid` and `tk_load` are low and `ev_ready` is high.
- R2: Event codes on `ev_kind` are 0 start, 1 address byte, 2 write byte, 3 read request and 4 stop. An address byte whose bits 7:1 equal 1101111 selects the block, and its bit 0 picks read (1) or write (0). Any other address leaves the block deselected, and write bytes and read requests are then ignored.
- R3: In a selected write transaction the first write byte loads the pointer. Each later byte is written at the pointer, and the pointer then advances.
- R4: The pointer advances by one, except at the last byte of a section: 06h goes to 00h, 0Bh to 07h, 11h to 0Ch and 13h to 12h. This applies to both reads and writes.
- R5: A byte written to 00h–06h raises `tk_load` for one cycle, on the cycle after the byte is accepted, with `tk_wr_idx` set to the address and `tk_wr_data` set to the byte. This happens only while bit 4 of 07h is 1. While that bit is 0 no strobe is issued, but the pointer still advances.
- R6: Address 09h always reads 00h, and writes to it are discarded.
- R7: At a pointer above 13h, writes change nothing, reads return 00h, and the pointer does not move.
- R8: The time bytes returned in a read transaction are the values of `tk_time` in the cycle in which the read address byte was accepted.
- R9: The pointer is kept after a stop, so a new read transaction without a pointer byte continues from the last address read plus one, with the R4 wrap applied.
- R10: `rd_valid` rises in the cycle after a selected read request is accepted. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low, and `ev_ready` is low whenever `rd_valid` is high.
- R11: A stop deselects the block, so write bytes that arrive after it, with no new start and address, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Byte event present |
| ev_ready | output | 1 | Block can take an event |
| ev_kind | input | 3 | Event code (see R2) |
| ev_data | input | 8 | Address or data byte of the event |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| tk_time | input | 56 | Live time bytes; byte n at bits 8n+7:8n |
| tk_load | output | 1 | Load strobe to the timekeeping counter |
| tk_wr_idx | output | 3 | Time byte index to load |
| tk_wr_data | output | 8 | Value to load |

## Verification
The bench builds the block with its default parameters: device address 1101111 and the time-write enable at bit 4 of 07h. Those values make every section boundary, the unused 09h and the region above 13h reachable with short transactions. A behavioural model runs in parallel with the block and predicts the read stream and the load strobes on every cycle. Directed transactions then exercise wrap in each section, gated time writes, a tick in the middle of a burst, a stalled consumer, a foreign device address and stray bytes after a stop.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW        = 8;
  localparam int CLK_BYTES = 7;
  localparam int CIW       = $clog2(CLK_BYTES);
  localparam int REG_COUNT = 20;
  localparam int IW        = $clog2(REG_COUNT);

  typedef logic [DW-1:0] byte_t;

  // Section bounds drive the wrap behaviour.
  localparam byte_t CLK_FIRST = 8'h00;
  localparam byte_t CLK_LAST  = 8'h06;
  localparam byte_t CTL_FIRST = 8'h07;
  localparam byte_t CTL_LAST  = 8'h0B;
  localparam byte_t ALM_FIRST = 8'h0C;
  localparam byte_t ALM_LAST  = 8'h11;
  localparam byte_t RAM_FIRST = 8'h12;
  localparam byte_t RAM_LAST  = 8'h13;
  localparam byte_t HOLE_ADDR = 8'h09;
  localparam byte_t CTL_ADDR  = 8'h07;

  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_ADDR  = 3'd1,
    EV_WRITE = 3'd2,
    EV_READ  = 3'd3,
    EV_STOP  = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/rtc_ptr_step.sv
module rtc_ptr_step
  import rtc_pkg::*;
(
  input  byte_t cur,
  output byte_t nxt
);
  always_comb begin
    if (cur == CLK_LAST)      nxt = CLK_FIRST;
    else if (cur == CTL_LAST) nxt = CTL_FIRST;
    else if (cur == ALM_LAST) nxt = ALM_FIRST;
    else if (cur == RAM_LAST) nxt = RAM_FIRST;
    else if (cur > RAM_LAST)  nxt = cur;
    else                      nxt = cur + byte_t'(1);
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [CLK_BYTES*DW-1:0] live,
  input  logic [CIW-1:0]          sel,
  output byte_t                   byte_out
);
  logic [CLK_BYTES*DW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= live;
  end

  assign byte_out = (int'(sel) < CLK_BYTES) ? held[int'(sel)*DW +: DW] : '0;
endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_pkg::*;
#(
  parameter int WREN_BIT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t waddr,
  input  byte_t wdata,
  input  byte_t raddr,
  output byte_t rdata,
  output logic  wren
);
  localparam byte_t REG_END = byte_t'(REG_COUNT);

  logic [REG_COUNT*DW-1:0] flat;

  for (genvar a = 0; a < REG_COUNT; a++) begin : g_reg
    if (byte_t'(a) < CTL_FIRST || byte_t'(a) == HOLE_ADDR) begin : g_none
      assign flat[a*DW +: DW] = '0;
    end else begin : g_ff
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (we && waddr == byte_t'(a))  q <= wdata;
      end
      assign flat[a*DW +: DW] = q;
    end
  end

  assign rdata = (raddr < REG_END) ? flat[int'(raddr[IW-1:0])*DW +: DW] : '0;
  assign wren  = flat[int'(CTL_ADDR)*DW + WREN_BIT];
endmodule

// File: rtl/rtc_regfile_ctrl.sv
module rtc_regfile_ctrl
  import rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101111,
  parameter int         WREN_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [2:0]              ev_kind,
  input  logic [DW-1:0]           ev_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [DW-1:0]           rd_data,
  input  logic [CLK_BYTES*DW-1:0] tk_time,
  output logic                    tk_load,
  output logic [CIW-1:0]          tk_wr_idx,
  output logic [DW-1:0]           tk_wr_data
);
  ev_kind_e kind;
  logic     fire, match;
  logic     sel_q, rd_mode_q, need_ptr_q;
  byte_t    ptr_q, ptr_nxt;
  logic     in_clk, wren;
  logic     ptr_fire, wr_fire, rd_fire, snap_take;
  byte_t    snap_byte, store_byte;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = !rd_valid;
  assign fire     = ev_valid && ev_ready;
  assign match    = (ev_data[DW-1:1] == DEV_ADDR);
  assign in_clk   = (ptr_q <= CLK_LAST);

  assign ptr_fire  = fire && kind == EV_WRITE && sel_q && !rd_mode_q && need_ptr_q;
  assign wr_fire   = fire && kind == EV_WRITE && sel_q && !rd_mode_q && !need_ptr_q;
  assign rd_fire   = fire && kind == EV_READ && sel_q && rd_mode_q;
  assign snap_take = fire && kind == EV_ADDR && match && ev_data[0];

  rtc_ptr_step u_step (
    .cur (ptr_q),
    .nxt (ptr_nxt)
  );

  rtc_snapshot u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (snap_take),
    .live     (tk_time),
    .sel      (ptr_q[CIW-1:0]),
    .byte_out (snap_byte)
  );

  rtc_store #(.WREN_BIT(WREN_BIT)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire && !in_clk),
    .waddr (ptr_q),
    .wdata (ev_data),
    .raddr (ptr_q),
    .rdata (store_byte),
    .wren  (wren)
  );

  // Transaction state and pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      rd_mode_q  <= 1'b0;
      need_ptr_q <= 1'b0;
      ptr_q      <= '0;
    end else begin
      if (fire && (kind == EV_START || kind == EV_STOP)) sel_q <= 1'b0;
      if (fire && kind == EV_ADDR) begin
        sel_q      <= match;
        rd_mode_q  <= ev_data[0];
        need_ptr_q <= !ev_data[0];
      end
      if (ptr_fire) begin
        ptr_q      <= ev_data;
        need_ptr_q <= 1'b0;
      end else if (wr_fire || rd_fire) begin
        ptr_q <= ptr_nxt;
      end
    end
  end

  // Read byte output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_fire) begin
      rd_valid <= 1'b1;
      rd_data  <= in_clk ? snap_byte : store_byte;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // Load strobe to the timekeeping counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_load    <= 1'b0;
      tk_wr_idx  <= '0;
      tk_wr_data <= '0;
    end else begin
      tk_load <= wr_fire && in_clk && wren;
      if (wr_fire && in_clk) begin
        tk_wr_idx  <= ptr_q[CIW-1:0];
        tk_wr_data <= ev_data;
      end
    end
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [2:0]    ev_kind,
  input logic [DW-1:0] ev_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          tk_load,
  input logic [CIW-1:0] tk_wr_idx,
  input logic [DW-1:0] tk_wr_data
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (!rd_valid && !tk_load));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !ev_ready);

  p_load_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |-> $past(ev_valid && ev_ready && ev_kind == 3'd2));

  p_load_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |-> tk_wr_data == $past(ev_data));

  p_load_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |-> int'(tk_wr_idx) < CLK_BYTES);
endmodule

bind rtc_regfile_ctrl rtc_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_kind    (ev_kind),
  .ev_data    (ev_data),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .tk_load    (tk_load),
  .tk_wr_idx  (tk_wr_idx),
  .tk_wr_data (tk_wr_data)
);

// File: tb/tb_rtc_regfile_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_regfile_ctrl;
  localparam logic [2:0] K_START = 3'd0, K_ADDR = 3'd1, K_WRITE = 3'd2,
                         K_READ = 3'd3, K_STOP = 3'd4;
  localparam logic [7:0] A_WR = 8'hDE, A_RD = 8'hDF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_kind = 3'd0;
  logic [7:0]  ev_data = 8'h00;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic [55:0] tk_time;
  logic        tk_load;
  logic [2:0]  tk_wr_idx;
  logic [7:0]  tk_wr_data;

  logic [7:0] live [7] = '{8'h30, 8'h45, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24};
  int errors = 0;
  int checks = 0;
  int n_loads = 0;
  int last_idx = -1;
  int last_dat = -1;

  assign tk_time = {live[6], live[5], live[4], live[3], live[2], live[1], live[0]};

  always #2.5 clk = ~clk;

  rtc_regfile_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_data(ev_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .tk_time(tk_time), .tk_load(tk_load),
    .tk_wr_idx(tk_wr_idx), .tk_wr_data(tk_wr_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // External timekeeping counter: takes loads from the block
  always @(negedge clk) begin
    if (rst_n && tk_load) begin
      live[tk_wr_idx] = tk_wr_data;
      n_loads++;
      last_idx = int'(tk_wr_idx);
      last_dat = int'(tk_wr_data);
    end
  end

  // Behavioural reference model
  int  m_reg [20];
  int  m_snap [7];
  bit  m_sel, m_rd, m_need, m_rv, m_ld;
  int  m_ptr, m_rdat, m_idx, m_dat;

  function automatic int step(input int p);
    int lo [4] = '{0, 7, 12, 18};
    int hi [4] = '{6, 11, 17, 19};
    if (p > 19) return p;
    for (int s = 0; s < 4; s++) if (p == hi[s]) return lo[s];
    return p + 1;
  endfunction

  function automatic int m_read(input int p);
    if (p <= 6) return m_snap[p];
    if (p <= 19 && p != 9) return m_reg[p];
    return 0;
  endfunction

  always @(posedge clk) begin
    bit old_rv;
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      foreach (m_snap[i]) m_snap[i] = 0;
      m_sel = 0; m_rd = 0; m_need = 0; m_rv = 0; m_ld = 0;
      m_ptr = 0; m_rdat = 0; m_idx = 0; m_dat = 0;
    end else begin
      old_rv = m_rv;
      m_ld = 0;
      if (old_rv && rd_ready) m_rv = 0;
      if (ev_valid && !old_rv) begin
        case (ev_kind)
          K_START, K_STOP: m_sel = 0;
          K_ADDR: begin
            m_sel  = (ev_data[7:1] == 7'b1101111);
            m_rd   = ev_data[0];
            m_need = !ev_data[0];
            if (m_sel && m_rd) for (int i = 0; i < 7; i++) m_snap[i] = live[i];
          end
          K_WRITE: if (m_sel && !m_rd) begin
            if (m_need) begin
              m_ptr = ev_data; m_need = 0;
            end else begin
              if (m_ptr <= 6) begin
                if (m_reg[7][4]) begin m_ld = 1; m_idx = m_ptr; m_dat = ev_data; end
              end else if (m_ptr <= 19 && m_ptr != 9) m_reg[m_ptr] = ev_data;
              m_ptr = step(m_ptr);
            end
          end
          K_READ: if (m_sel && m_rd) begin
            m_rv = 1; m_rdat = m_read(m_ptr); m_ptr = step(m_ptr);
          end
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 model rd_valid", rd_valid, m_rv);
      if (m_rv) chk("R10 model rd_data", rd_data, m_rdat);
      chk("R5 model tk_load", tk_load, m_ld);
      if (m_ld) begin
        chk("R5 model tk_wr_idx", tk_wr_idx, m_idx);
        chk("R5 model tk_wr_data", tk_wr_data, m_dat);
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [7:0] d);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_data = d;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic start_w(input logic [7:0] p);
    send(K_START, 8'h00); send(K_ADDR, A_WR); send(K_WRITE, p);
  endtask

  task automatic start_r();
    send(K_START, 8'h00); send(K_ADDR, A_RD);
  endtask

  task automatic stop();
    send(K_STOP, 8'h00);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    start_w(p); stop();
  endtask

  task automatic rd_chk(input string tag, input int exp);
    send(K_READ, 8'h00);
    for (int n = 0; n < 8 && !rd_valid; n++) @(negedge clk);
    chk(tag, rd_valid ? int'(rd_data) : -1, exp);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 tk_load after reset", tk_load, 0);
    chk("R1 ev_ready after reset", ev_ready, 1);
    start_r(); rd_chk("R1 pointer starts at 00h", 8'h30); stop();
    set_ptr(8'h07); start_r(); rd_chk("R1 stored reg reset value", 8'h00); stop();

    // R3 burst write, R9 pointer carried across transactions
    start_w(8'h0C); send(K_WRITE, 8'h11); send(K_WRITE, 8'h22); send(K_WRITE, 8'h33); stop();
    set_ptr(8'h0C); start_r();
    rd_chk("R3 byte at 0Ch", 8'h11); rd_chk("R3 byte at 0Dh", 8'h22); stop();
    start_r(); rd_chk("R9 current-address read continues at 0Eh", 8'h33); stop();

    // R4 wrap in the RAM section on write and read
    start_w(8'h12); send(K_WRITE, 8'hAA); send(K_WRITE, 8'hBB); send(K_WRITE, 8'hCC); stop();
    set_ptr(8'h12); start_r();
    rd_chk("R4 ram 12h after write wrap", 8'hCC); rd_chk("R4 ram 13h", 8'hBB);
    rd_chk("R4 read wraps 13h to 12h", 8'hCC); stop();

    // R4 wrap in the control section; sets time-write enable
    start_w(8'h0B); send(K_WRITE, 8'h5A); send(K_WRITE, 8'h10); stop();
    set_ptr(8'h0B); start_r();
    rd_chk("R4 ctl 0Bh", 8'h5A); rd_chk("R4 ctl wraps to 07h", 8'h10); stop();

    // R5 enabled time writes, R4 wrap 06h to 00h
    start_w(8'h05); send(K_WRITE, 8'h59); send(K_WRITE, 8'h41); send(K_WRITE, 8'h27); stop();
    @(negedge clk);
    chk("R5 three load strobes", n_loads, 3);
    chk("R4 last load wrapped to index 0", last_idx, 0);
    chk("R5 last load data", last_dat, 8'h27);
    set_ptr(8'h05); start_r();
    rd_chk("R5 time 05h loaded", 8'h59); rd_chk("R5 time 06h loaded", 8'h41);
    rd_chk("R4 time read wraps to 00h", 8'h27); stop();

    // R5 disabled time writes still advance the pointer
    start_w(8'h07); send(K_WRITE, 8'h00); stop();
    start_w(8'h02); send(K_WRITE, 8'h77); stop();
    @(negedge clk);
    chk("R5 no strobe while disabled", n_loads, 3);
    start_r(); rd_chk("R5 pointer advanced past 02h", 8'h03); stop();
    set_ptr(8'h02); start_r(); rd_chk("R5 time 02h unchanged", 8'h12); stop();

    // R6 unused 09h
    start_w(8'h08); send(K_WRITE, 8'h01); send(K_WRITE, 8'hFF); send(K_WRITE, 8'h02); stop();
    set_ptr(8'h08); start_r();
    rd_chk("R6 08h", 8'h01); rd_chk("R6 09h reads zero", 8'h00); rd_chk("R6 0Ah", 8'h02); stop();

    // R7 beyond 13h
    start_w(8'h20); send(K_WRITE, 8'h55); send(K_WRITE, 8'h66); stop();
    start_r(); rd_chk("R7 read above 13h", 8'h00); rd_chk("R7 pointer does not move", 8'h00); stop();
    set_ptr(8'h13); start_r(); rd_chk("R7 no aliasing into 13h", 8'hBB); stop();
    set_ptr(8'h0D); start_r(); rd_chk("R7 no aliasing into 0Dh", 8'h22); stop();

    // R8 snapshot stays fixed during a burst
    set_ptr(8'h00); start_r();
    rd_chk("R8 time 00h", 8'h27);
    @(negedge clk); live[1] = 8'h46;
    rd_chk("R8 tick hidden from burst", 8'h45); stop();
    set_ptr(8'h01); start_r(); rd_chk("R8 new burst sees tick", 8'h46); stop();

    // R10 stalled consumer
    set_ptr(8'h0C); start_r();
    rd_ready = 1'b0;
    send(K_READ, 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk("R10 valid held", rd_valid, 1);
      chk("R10 data held", rd_data, 8'h11);
      chk("R10 ev_ready low while busy", ev_ready, 0);
      @(negedge clk);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    chk("R10 valid drops after accept", rd_valid, 0);
    stop();

    // R2 foreign device address
    send(K_START, 8'h00); send(K_ADDR, 8'hA0); send(K_WRITE, 8'h12); send(K_WRITE, 8'h99); stop();
    send(K_START, 8'h00); send(K_ADDR, 8'hA1); send(K_READ, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 no read for foreign address", rd_valid, 0);
    stop();
    set_ptr(8'h12); start_r(); rd_chk("R2 foreign write ignored", 8'hCC); stop();

    // R11 bytes after stop ignored
    start_w(8'h12); send(K_WRITE, 8'h44); stop();
    send(K_WRITE, 8'h66);
    set_ptr(8'h12); start_r();
    rd_chk("R11 12h keeps in-transaction byte", 8'h44);
    rd_chk("R11 13h untouched by stray byte", 8'hBB); stop();

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule